// File: doc/BRIEF.md
# Chunked SPI Flash Read Sequencer

This block copies a contiguous region of a serial flash device into a local byte-wide write port. A request carries a 24-bit flash start address, a byte count and a destination base address. The sequencer splits the request into pieces small enough for its 64-entry receive buffer. For each piece it runs one standard read transaction on a mode-0 SPI link that it drives itself. Bytes from each transaction are buffered until the whole transaction has landed. The bytes clocked back while the header went out are then thrown away, and the rest are written out at incrementing destination addresses.

Between transactions of one request, chip select stays high for a programmable number of clock cycles. The default is 100 cycles, about 1 µs at 100 MHz, which is well above the 100 ns that typical flash parts need. A one-cycle done pulse marks the end of a request. A typical boot flow issues two requests to the same flash offset: a short one to fetch a 64-byte image header, then a longer one to fetch the whole image.

Top module: `spi_bulk_reader`

## Requirements
- R1: Every transaction shifts out the read opcode 0x03 first, followed by the 24-bit flash address with its most significant byte first, MSB-first within each byte (SPI mode 0: SCLK idles low, data is sampled on the rising edge).
- R2: A transaction carries at most 60 payload bytes. A request is served as full 60-byte pieces followed by one shorter remainder piece, if any.
- R3: A transaction with a piece of N bytes clocks exactly 4+N bytes while chip select is low. Only the first 4 bytes carry meaningful transmit data, and MOSI stays low during the N payload bytes.
- R4: The first 4 bytes received in each transaction are discarded. The remaining bytes go out on the write port in arrival order, with a destination address equal to the base address plus the byte's offset within the request.
- R5: After each piece, the flash address advances by the piece length, and the request produces exactly as many writes as its byte count.
- R6: Between two transactions of one request, chip select stays high for at least GAP_CYCLES clock cycles.
- R7: No write leaves the block while chip select is low. Draining starts only after the buffer level has reached 4+N.
- R8: A request of length 0 gives a done pulse in the cycle after it is accepted, with busy staying low and no chip-select activity.
- R9: Busy is high from an accepted start until the done pulse, and is low in the done cycle. A start while busy is ignored. A start in the done cycle itself is accepted.
- R10: Out of reset, chip select is high, SCLK is low, and busy, done and the write enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| src_addr_i | input | 24 | Flash start address |
| len_i | input | LEN_W | Byte count of the request |
| dst_i | input | DST_W | Destination base address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| wr_en | output | 1 | Write strobe for one payload byte |
| wr_addr | output | DST_W | Destination address of the byte |
| wr_data | output | 8 | Payload byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The done pulse of one request and the acceptance of the next start can fall in the same cycle, because busy is already low while done is high. The bench provokes this by chaining requests: it raises start in exactly the cycle where it observes done. The chained request is then judged on its own commands, addresses, piece sizes, gaps and written bytes. A second overlap, a start arriving in the middle of a busy request, is provoked with different operands, and the original request's writes must be unaffected.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] READ_OPCODE = 8'h03;

  // piece length: remaining bytes capped at the per-transaction payload limit
  function automatic int unsigned piece_len(input int unsigned remaining,
                                            input int unsigned limit);
    return (remaining > limit) ? limit : remaining;
  endfunction

  // header byte by position: opcode, then address high to low
  function automatic logic [7:0] hdr_byte(input int unsigned idx,
                                          input logic [23:0] addr);
    case (idx)
      0:       return READ_OPCODE;
      1:       return addr[23:16];
      2:       return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction
endpackage

// File: rtl/sbr_shifter.sv
module sbr_shifter #(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       byte_done,
  output logic       active
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          half;
  logic [2:0]    bitn;
  logic [7:0]    tsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      half      <= 1'b0;
      cnt       <= '0;
      bitn      <= '0;
      tsh       <= '0;
      rx        <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        tsh    <= tx;
        bitn   <= 3'd7;
        half   <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
          if (!half) begin
            half <= 1'b1;
            rx   <= {rx[6:0], miso};
          end else begin
            half <= 1'b0;
            tsh  <= {tsh[6:0], 1'b0};
            if (bitn == 3'd0) begin
              active    <= 1'b0;
              byte_done <= 1'b1;
            end else begin
              bitn <= bitn - 3'd1;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign sclk = half;
  assign mosi = active & tsh[7];

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active); // R3
endmodule

// File: rtl/sbr_fifo.sv
module sbr_fifo #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [7:0]                 wdata,
  input  logic                       pop,
  output logic [7:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      level <= level + LW'(push) - LW'(pop);
    end
  end

  assign rdata = mem[rp];

  AST_FIFO_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (level < LW'(DEPTH))); // R2
  AST_FIFO_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (level != '0)); // R4
endmodule

// File: rtl/spi_bulk_reader.sv
module spi_bulk_reader
  import sbr_pkg::*;
#(
  parameter int LEN_W      = 16,
  parameter int DST_W      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int SCK_DIV    = 2,
  parameter int GAP_CYCLES = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      src_addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DST_W-1:0] dst_i,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [DST_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int MAX_PIECE = FIFO_DEPTH - HDR_BYTES;
  localparam int CW        = $clog2(FIFO_DEPTH + 1);
  localparam int GW        = $clog2(GAP_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_FILL, S_DRAIN} state_t;

  state_t           state;
  logic [23:0]      faddr;
  logic [LEN_W-1:0] rem;
  logic [DST_W-1:0] dptr;
  logic [CW-1:0]    piece, issued, got, popped;
  logic [GW-1:0]    gap_q;
  logic             cs_q, done_q;

  // events brought out for the checks
  logic          sh_go, sh_done, sh_active;
  logic [7:0]    sh_tx, sh_rx, fifo_rd;
  logic [CW-1:0] fifo_lvl, total;
  logic          fifo_pop, gap_ok, last_pop, accept;

  assign total    = CW'(HDR_BYTES) + piece;
  assign gap_ok   = (gap_q >= GW'(GAP_CYCLES));
  assign accept   = start && (state == S_IDLE);
  assign sh_go    = (state == S_XFER) && !sh_active && (issued < total);
  assign sh_tx    = (issued < CW'(HDR_BYTES)) ? hdr_byte(32'(issued), faddr) : 8'h00;
  assign fifo_pop = (state == S_DRAIN);
  assign last_pop = fifo_pop && (popped == total - CW'(1));

  sbr_shifter #(.DIV(SCK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(sh_rx), .byte_done(sh_done),
    .active(sh_active)
  );

  sbr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sh_done), .wdata(sh_rx),
    .pop(fifo_pop), .rdata(fifo_rd), .level(fifo_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      faddr  <= '0;
      rem    <= '0;
      dptr   <= '0;
      piece  <= '0;
      issued <= '0;
      got    <= '0;
      popped <= '0;
      gap_q  <= '0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cs_q && !gap_ok) gap_q <= gap_q + GW'(1);
      if (sh_go) issued <= issued + CW'(1);
      if (wr_en) dptr <= dptr + DST_W'(1);
      case (state)
        S_IDLE: if (accept) begin
          if (len_i == '0) begin
            done_q <= 1'b1;
          end else begin
            faddr <= src_addr_i;
            rem   <= len_i;
            dptr  <= dst_i;
            gap_q <= GW'(GAP_CYCLES);
            state <= S_LOAD;
          end
        end
        S_LOAD: begin
          piece <= CW'(piece_len(32'(rem), MAX_PIECE));
          if (gap_ok) begin
            issued <= '0;
            got    <= '0;
            cs_q   <= 1'b0;
            state  <= S_XFER;
          end
        end
        S_XFER: if (sh_done) begin
          got <= got + CW'(1);
          if (got == total - CW'(1)) begin
            cs_q  <= 1'b1;
            gap_q <= '0;
            state <= S_FILL;
          end
        end
        S_FILL: if (fifo_lvl >= total) begin
          popped <= '0;
          state  <= S_DRAIN;
        end
        S_DRAIN: begin
          popped <= popped + CW'(1);
          if (last_pop) begin
            faddr <= faddr + 24'(piece);
            rem   <= rem - LEN_W'(piece);
            if (rem == LEN_W'(piece)) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              state <= S_LOAD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign done     = done_q;
  assign spi_cs_n = cs_q;
  assign wr_en    = fifo_pop && (popped >= CW'(HDR_BYTES));
  assign wr_addr  = dptr;
  assign wr_data  = fifo_rd;

  AST_WR_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> spi_cs_n); // R7
  AST_PIECE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER) |-> (piece != '0 && piece <= CW'(MAX_PIECE))); // R2
  AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(gap_q) >= GW'(GAP_CYCLES)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && len_i == '0) |=> (done && spi_cs_n)); // R8
  AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_active && issued > CW'(HDR_BYTES)) |-> !spi_mosi); // R3
  AST_DRAIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_pop) |-> fifo_lvl == total); // R7
endmodule

// File: tb/spi_bulk_reader_tb.sv
module spi_bulk_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int DST_W = 16;
  localparam int GAP   = 100;
  localparam int MAXP  = 60;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] src_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic [DST_W-1:0] dst_i = '0;
  logic busy, done, wr_en, spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b1;
  logic [DST_W-1:0] wr_addr;
  logic [7:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bulk_reader #(.LEN_W(LEN_W), .DST_W(DST_W), .GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr_i(src_i), .len_i(len_i),
    .dst_i(dst_i), .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int nchecks = 0, nerr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h3C;
  endfunction

  function automatic int unsigned exp_piece(input int unsigned r);
    return (r > MAXP) ? MAXP : r;
  endfunction

  // flash model
  int s_bits = 0, s_mosi_bad = 0;
  logic [31:0] s_sr = '0;
  logic [7:0]  t_cmd = '0;
  logic [23:0] t_addr = '0;

  always @(negedge spi_cs_n) begin
    s_bits = 0; s_mosi_bad = 0; spi_miso = 1'b1;
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    if (s_bits >= 32 && spi_mosi) s_mosi_bad++;
    s_sr = {s_sr[30:0], spi_mosi};
    s_bits++;
    if (s_bits == 32) begin t_cmd = s_sr[31:24]; t_addr = s_sr[23:0]; end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (s_bits >= 32) begin
      automatic int b = s_bits - 32;
      automatic logic [7:0] v = fbyte(24'(t_addr + 24'(b / 8)));
      spi_miso = v[7 - (b % 8)];
    end else spi_miso = 1'b1;
  end

  // expectations and monitor
  logic [23:0] exp_faddr, exp_src;
  int unsigned exp_rem;
  logic [DST_W-1:0] exp_dst;
  int wcount = 0, txn_total = 0, gapc = 0;
  bit first_txn = 1, prev_cs = 1;

  always @(negedge clk) if (rst_n) begin
    if (wr_en) begin
      chk(wr_addr == exp_dst, "R4 dest addr", wr_addr, exp_dst);
      chk(wr_data == fbyte(exp_src), "R4 payload byte", wr_data, fbyte(exp_src));
      exp_dst++; exp_src++; wcount++;
    end
    if (prev_cs && !spi_cs_n) begin
      if (!first_txn) chk(gapc >= GAP, "R6 cs high gap", gapc, GAP);
      first_txn = 0; txn_total++;
    end
    if (!prev_cs && spi_cs_n) begin
      automatic int unsigned p = exp_piece(exp_rem);
      chk(t_cmd == 8'h03, "R1 opcode", t_cmd, 8'h03);
      chk(t_addr == exp_faddr, "R1 R5 flash addr", t_addr, exp_faddr);
      chk(s_bits == 32 + 8 * int'(p), "R2 R3 bits per transaction", s_bits, 32 + 8 * p);
      chk(s_mosi_bad == 0, "R3 mosi quiet in payload", s_mosi_bad, 0);
      exp_faddr += 24'(p); exp_rem -= p;
      gapc = 0;
    end
    if (spi_cs_n) gapc++;
    prev_cs = spi_cs_n;
  end

  task automatic run_req(input logic [23:0] a, input int unsigned n,
                         input logic [DST_W-1:0] d, input bit poke);
    int t0, k;
    exp_faddr = a; exp_src = a; exp_rem = n; exp_dst = d;
    wcount = 0; first_txn = 1; t0 = txn_total;
    src_i = a; len_i = LEN_W'(n); dst_i = d; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R8 done after zero length", done, 1);
      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
      @(negedge clk);
      chk(txn_total == t0 && spi_cs_n, "R8 no spi activity", txn_total - t0, 0);
      return;
    end
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    k = 0;
    while (!done && k < 100000) begin
      if (poke && k == 40) begin
        src_i = ~a; len_i = 5; dst_i = ~d; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk); k++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(busy == 1'b0, "R9 busy low at done", busy, 0);
    chk(wcount == int'(n), "R5 write count", wcount, n);
    chk(exp_rem == 0, "R2 pieces cover request", exp_rem, 0);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++; nchecks++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(spi_cs_n == 1'b1, "R10 cs idle", spi_cs_n, 1);
    chk(spi_sclk == 1'b0, "R10 sclk idle", spi_sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R10 busy/done idle", {busy, done}, 0);
    chk(wr_en == 1'b0, "R10 no write", wr_en, 0);

    run_req(24'h000100, 0, 16'h0000, 0);     // R8
    idle(3);
    run_req(24'h012345, 1, 16'h0200, 0);
    idle(3);
    run_req(24'h0ABCDE, 59, 16'h0300, 0);
    idle(3);
    run_req(24'h100000, 60, 16'h0400, 0);    // R2 exact limit
    idle(3);
    run_req(24'h200010, 61, 16'h0500, 0);    // R2 one over
    idle(3);
    run_req(24'h3000F0, 121, 16'h0600, 1);   // R9 start while busy
    idle(3);
    run_req(24'h008000, 64, 16'h1000, 0);    // header then image, same offset
    run_req(24'h008000, 300, 16'h1000, 0);   // R9 start in done cycle
    run_req(24'h000000, 0, 16'h0000, 0);     // R8 chained zero length
    run_req(24'hFFFFF0, 20, 16'h2000, 0);    // chained, address near top
    idle(3);
    for (int i = 0; i < 6; i++) begin
      automatic int unsigned n = $urandom_range(150, 1);
      run_req(24'($urandom), n, DST_W'($urandom), (i % 2) == 1);
      idle($urandom_range(4, 0));
    end
    idle(5);
    finish_run();
  end
endmodule